// File: doc/BRIEF.md
# Interrupt Distributor Global Control Registers

This block is the small register file that sits at the front of an interrupt distributor and serves its global words: a control word holding the single group-1 enable flag, a type word computed from configuration straps, an identification word built from two code parameters, and a peripheral-identification window near the top of the address space. Software reaches it through a simple 32-bit register bus with a one-cycle request strobe, a write flag, a byte address and write data. Reads answer one cycle later on a registered data bus with a valid pulse.

The type word is not stored; it is formed from the configured count of shared interrupts and from a strap saying whether message-based interrupts are supported. The control word reports two fixed capability bits that always read as one, whatever software writes. When a control write turns the distributor on from the off state, a one-cycle notify pulse tells the delivery logic to re-scan its pending work; rewriting the flag while it is already set gives no pulse.

Top module: `dist_ctl_regs`

## Requirements
- R1: Inside the low 16-byte window (address bits above bit 3 all zero) address bits 3:2 pick the word: 0 control, 1 type, 2 identification, 3 reads as zero.
- R2: A control read returns the stored enable in bit 1, a one in bit 4 (routing enabled) and a one in bit 6 (single security state), and zero in every other bit.
- R3: Type word bits 4:0 equal (shared-interrupt count + 32) / 32 − 1, evaluated on the current strap value.
- R4: Type word bits 23:19 hold 9 when the message-interrupt strap is low and 15 when it is high; bit 17 is one exactly when the strap is high; all other type bits read zero.
- R5: The identification word carries the product code parameter in bits 31:24, the implementer code parameter in bits 7:0 and zeros elsewhere.
- R6: Writes to the type word, the identification word, offset 12, the identification window or any unmapped address leave the enable unchanged; a control write stores only bit 1 of the write data.
- R7: The notify output is high for exactly one cycle, the cycle after a control write that takes the enable from 0 to 1; rewriting a set enable, clearing it, or writing 0 while clear gives no pulse.
- R8: In the 48-byte identification window starting at the base parameter (default 0xFFD0), the word at base + 0x18 (0xFFE8) reads 0x0000003B and every other word reads zero; any address outside both windows reads zero.
- R9: Reset (synchronous, active high) clears the enable; read data and its valid pulse appear in the cycle after the read strobe, and the valid is low in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle read data is valid |
| shared_count | input | SPI_W | Number of shared interrupts configured |
| msg_irq_en | input | 1 | Strap: message-based interrupts supported |
| grp1_en | output | 1 | Current group-1 enable flag |
| notify | output | 1 | One-cycle pulse on off-to-on enable |

## Verification
The only state is the enable flag and the read register, so a wrong enable shows at once on the `grp1_en` port and on bit 1 of the next control read, while a spurious or missing notify is visible in the single cycle after the offending write. Decode mistakes appear as the wrong word one cycle after a read strobe, so every address class is read back with known straps. The type word is exercised at several shared counts with the strap in both states, catching an off-by-one in the line-count formula or a field placed at the wrong bit.

// File: rtl/dist_ctl_pkg.sv
package dist_ctl_pkg;

    typedef enum logic [2:0] {
        SEL_CTL,
        SEL_TYPE,
        SEL_IDENT,
        SEL_ZERO,
        SEL_PID2,
        SEL_NONE
    } reg_sel_e;

    // control word bit positions
    localparam int CTL_EN_BIT    = 1;
    localparam int CTL_ROUTE_BIT = 4;
    localparam int CTL_NOSEC_BIT = 6;

    // type word fields
    localparam int TYPE_LINES_W  = 5;
    localparam int TYPE_IDW_LSB  = 19;
    localparam int TYPE_IDW_W    = 5;
    localparam int TYPE_MSG_BIT  = 17;
    localparam int IDW_PLAIN     = 10;
    localparam int IDW_MSG       = 16;

    localparam logic [31:0] PID2_VALUE = 32'h0000_003B;
    localparam int          PID2_WORD  = 6;
    localparam int          ID_WORDS   = 12;

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } rd_beat_t;

    function automatic logic [31:0] ctl_word(input logic en);
        logic [31:0] w;
        w = '0;
        w[CTL_EN_BIT]    = en;
        w[CTL_ROUTE_BIT] = 1'b1;
        w[CTL_NOSEC_BIT] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] type_word(input logic [15:0] n_shared, input logic msg);
        logic [31:0] w;
        logic [16:0] lines;
        w     = '0;
        lines = ({1'b0, n_shared} + 17'd32) >> 5;
        w[TYPE_LINES_W-1:0] = lines[TYPE_LINES_W-1:0] - 1'b1;
        if (msg) begin
            w[TYPE_IDW_LSB +: TYPE_IDW_W] = TYPE_IDW_W'(IDW_MSG - 1);
            w[TYPE_MSG_BIT] = 1'b1;
        end else begin
            w[TYPE_IDW_LSB +: TYPE_IDW_W] = TYPE_IDW_W'(IDW_PLAIN - 1);
        end
        return w;
    endfunction

    function automatic logic [31:0] ident_word(input logic [7:0] prod, input logic [7:0] impl);
        return {prod, 16'h0000, impl};
    endfunction

endpackage

// File: rtl/dist_ctl_decode.sv
module dist_ctl_decode
    import dist_ctl_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] ID_BASE = 16'hFFD0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] ID_FIRST = ID_BASE[ADDR_W-1:2];
    localparam logic [WA_W-1:0] ID_LAST  = ID_FIRST + WA_W'(ID_WORDS - 1);
    localparam logic [WA_W-1:0] ID_PID2  = ID_FIRST + WA_W'(PID2_WORD);

    logic [WA_W-1:0] word;
    logic            in_low;
    logic            in_id;

    assign word   = addr[ADDR_W-1:2];
    assign in_low = (addr[ADDR_W-1:4] == '0);
    assign in_id  = (word >= ID_FIRST) && (word <= ID_LAST);

    always_comb begin
        sel = SEL_NONE;
        if (in_low) begin
            unique case (addr[3:2])
                2'd0: sel = SEL_CTL;
                2'd1: sel = SEL_TYPE;
                2'd2: sel = SEL_IDENT;
                default: sel = SEL_ZERO;
            endcase
        end else if (in_id && word == ID_PID2) begin
            sel = SEL_PID2;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/dist_ctl_enable.sv
module dist_ctl_enable
    import dist_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_ctl,
    input  logic wr_bit,
    output logic en,
    output logic notify
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            notify <= 1'b0;
        end else begin
            notify <= wr_ctl && wr_bit && !en;
            if (wr_ctl) begin
                en <= wr_bit;
            end
        end
    end
endmodule

// File: rtl/dist_ctl_rdport.sv
module dist_ctl_rdport
    import dist_ctl_pkg::*;
#(
    parameter int         SPI_W        = 10,
    parameter logic [7:0] PRODUCT_CODE = 8'h4B,
    parameter logic [7:0] IMPL_CODE    = 8'h3B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_stb,
    input  reg_sel_e         sel,
    input  logic             en,
    input  logic [SPI_W-1:0] shared_count,
    input  logic             msg_irq_en,
    output rd_beat_t         beat
);
    logic [15:0] count_ext;
    logic [31:0] mux_data;

    assign count_ext = 16'(shared_count);

    always_comb begin
        unique case (sel)
            SEL_CTL:   mux_data = ctl_word(en);
            SEL_TYPE:  mux_data = type_word(count_ext, msg_irq_en);
            SEL_IDENT: mux_data = ident_word(PRODUCT_CODE, IMPL_CODE);
            SEL_PID2:  mux_data = PID2_VALUE;
            default:   mux_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.vld  <= rd_stb;
            beat.data <= rd_stb ? mux_data : '0;
        end
    end
endmodule

// File: rtl/dist_ctl_regs.sv
module dist_ctl_regs
    import dist_ctl_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                SPI_W        = 10,
    parameter logic [ADDR_W-1:0] ID_BASE      = 16'hFFD0,
    parameter logic [7:0]        PRODUCT_CODE = 8'h4B,
    parameter logic [7:0]        IMPL_CODE    = 8'h3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [SPI_W-1:0]  shared_count,
    input  logic              msg_irq_en,
    output logic              grp1_en,
    output logic              notify
);
    reg_sel_e sel;
    rd_beat_t beat;
    logic     wr_ctl;
    logic     rd_stb;

    dist_ctl_decode #(.ADDR_W(ADDR_W), .ID_BASE(ID_BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_ctl = bus_req && bus_we && (sel == SEL_CTL);
    assign rd_stb = bus_req && !bus_we;

    dist_ctl_enable u_en (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (wr_ctl),
        .wr_bit (bus_wdata[CTL_EN_BIT]),
        .en     (grp1_en),
        .notify (notify)
    );

    dist_ctl_rdport #(
        .SPI_W(SPI_W), .PRODUCT_CODE(PRODUCT_CODE), .IMPL_CODE(IMPL_CODE)
    ) u_rd (
        .clk          (clk),
        .rst          (rst),
        .rd_stb       (rd_stb),
        .sel          (sel),
        .en           (grp1_en),
        .shared_count (shared_count),
        .msg_irq_en   (msg_irq_en),
        .beat         (beat)
    );

    assign bus_rdata  = beat.data;
    assign bus_rvalid = beat.vld;
endmodule

// File: rtl/dist_ctl_regs_chk.sv
module dist_ctl_regs_chk
    import dist_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              grp1_en,
    input logic              notify
);
    logic is_ctl;
    assign is_ctl = (bus_addr[ADDR_W-1:4] == '0) && (bus_addr[3:2] == 2'd0);

    // R7
    notify_edge_chk: assert property (@(posedge clk) disable iff (rst)
        notify |-> (grp1_en && !$past(grp1_en)));

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    // R2
    ctl_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && is_ctl) |=>
            (bus_rdata[CTL_ROUTE_BIT] && bus_rdata[CTL_NOSEC_BIT]
             && bus_rdata[CTL_EN_BIT] == grp1_en));

    // R6
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !is_ctl) |=> $stable(grp1_en));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !grp1_en);
endmodule

bind dist_ctl_regs dist_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .grp1_en    (grp1_en),
    .notify     (notify)
);

// File: tb/dist_ctl_regs_test.sv
`timescale 1ns/1ps
module dist_ctl_regs_test;
    localparam int ADDR_W = 16;
    localparam int SPI_W  = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [SPI_W-1:0]  shared_count = '0;
    logic              msg_irq_en = 1'b0;
    logic              grp1_en;
    logic              notify;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dist_ctl_regs uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .shared_count(shared_count),
        .msg_irq_en(msg_irq_en), .grp1_en(grp1_en), .notify(notify)
    );

    function automatic logic [31:0] exp_ctl(input logic en);
        return 32'h0000_0050 | (32'(en) << 1);
    endfunction

    function automatic logic [31:0] exp_type(input int n, input logic msg);
        logic [31:0] w;
        w = 32'((n + 32) / 32 - 1);
        w = w | (msg ? ((32'd15 << 19) | (32'd1 << 17)) : (32'd9 << 19));
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: push expectation, issue one read strobe
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // monitor: pop and compare on every valid beat
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9: actual=unexpected beat %h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset enable", {31'b0, grp1_en}, 32'd0);
        check("R9 reset valid", {31'b0, bus_rvalid}, 32'd0);
        rst = 1'b0;

        // R1 R2 control word and window decode
        do_read(16'h0000, exp_ctl(1'b0), "R2 ctl after reset");
        do_read(16'h000C, 32'h0, "R1 offset 12 zero");
        do_read(16'h0100, 32'h0, "R8 unmapped zero");

        // R3 R4 type word across counts and strap
        shared_count = 10'd32;  do_read(16'h0004, exp_type(32, 1'b0), "R3 type n=32");
        shared_count = 10'd64;  do_read(16'h0004, exp_type(64, 1'b0), "R3 type n=64");
        shared_count = 10'd988; do_read(16'h0004, exp_type(988, 1'b0), "R3 type n=988");
        shared_count = 10'd0;   do_read(16'h0004, exp_type(0, 1'b0), "R3 type n=0");
        msg_irq_en = 1'b1; shared_count = 10'd988;
        do_read(16'h0004, exp_type(988, 1'b1), "R4 type msg strap");
        msg_irq_en = 1'b0;

        // R5 identification
        do_read(16'h0008, 32'h4B00_003B, "R5 ident word");

        // R8 id window
        do_read(16'hFFE8, 32'h0000_003B, "R8 pid2");
        do_read(16'hFFD0, 32'h0, "R8 id first");
        do_read(16'hFFFC, 32'h0, "R8 id last");

        // R6 ignored writes while disabled
        do_write(16'h0004, 32'hFFFF_FFFF);
        check("R6 type write ignored", {31'b0, grp1_en}, 32'd0);
        check("R6 no notify", {31'b0, notify}, 32'd0);
        do_write(16'h0008, 32'h0000_0002);
        do_write(16'hFFE8, 32'h0000_0002);
        check("R6 ident/id writes ignored", {31'b0, grp1_en}, 32'd0);
        do_read(16'h0008, 32'h4B00_003B, "R6 ident unchanged");

        // R7 enable rising: pulse one cycle
        do_write(16'h0000, 32'h0000_0002);
        check("R7 notify on enable", {31'b0, notify}, 32'd1);
        check("R6 enable stored", {31'b0, grp1_en}, 32'd1);
        @(negedge clk);
        check("R7 notify one cycle", {31'b0, notify}, 32'd0);
        do_read(16'h0000, exp_ctl(1'b1), "R2 ctl enabled");

        // R7 rewrite while set
        do_write(16'h0000, 32'h0000_0002);
        check("R7 no notify on rewrite", {31'b0, notify}, 32'd0);

        // R6 only bit 1 is taken
        do_write(16'h0000, 32'hFFFF_FFFD);
        check("R6 ctl takes bit1 only", {31'b0, grp1_en}, 32'd0);
        check("R7 no notify on disable", {31'b0, notify}, 32'd0);
        do_read(16'h0000, exp_ctl(1'b0), "R2 ctl fixed bits");
        do_write(16'h0000, 32'h0000_0000);
        check("R7 no notify writing 0", {31'b0, notify}, 32'd0);

        // R9 reset clears a set enable
        do_write(16'h0000, 32'h0000_0002);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 reset clears enable", {31'b0, grp1_en}, 32'd0);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R9: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule